// File: doc/BRIEF.md
# Double-Buffered Scaler Coefficient Loader

This block fills one bank of a two-bank polyphase coefficient store while the scaler keeps filtering from the other bank. A single start pulse carries the filter type, the tap count of the filter being loaded, the tap count of the companion plane in the same direction, and the chroma coefficient mode to apply. The loader walks through the stored half of the phase table. For every phase it fetches coefficients from a synchronous source memory, one cycle of read latency, and issues one paired write per tap pair. When the last pair has been written, it flips the bank select so that the scaler moves to the freshly written bank.

Because the filter is symmetric, only phases 0 to NUM_PHASES/2 are written, 33 phases by default. Each write carries an even tap and the odd tap after it. A tap that lies beyond the tap count is written as zero. Two cases need no table and load nothing: a one-tap filter, and a direction where both planes use exactly two taps, because that case uses fixed built-in coefficients.

The sequencer moves through five states. IDLE waits for an accepted start. RD_EVEN presents the even-tap address. RD_ODD captures the even coefficient and presents the odd-tap address. WRITE captures the odd coefficient and issues the paired write. SWAP toggles the bank. The transitions are:
- IDLE to RD_EVEN on an accepted start.
- RD_EVEN to RD_ODD, always.
- RD_ODD to WRITE, always.
- WRITE to RD_EVEN when pairs remain.
- WRITE to SWAP after the final pair of the final phase.
- SWAP to IDLE, always.

Top module: `coef_bank_loader`

## Requirements
- R1: After reset, bank_sel, chroma_mode, busy and wr_en are all 0.
- R2: A load issues exactly 33*ceil(taps/2) writes, in ascending phase order 0..32, and within each phase in ascending pair index 0..ceil(taps/2)-1.
- R3: The write for phase p and pair k carries on wr_even the source word at address p*taps+2k, and on wr_odd the source word at address p*taps+2k+1. Bits 1:0 of both words are forced to 0.
- R4: When 2k+1 is greater than or equal to taps, wr_odd is 0.
- R5: Every write has wr_even_en and wr_odd_en both at 1. Every write carries the latched filter type on wr_type, encoded as follows: 0 luma vertical, 1 luma horizontal, 2 chroma vertical, 3 chroma horizontal, 4 alpha vertical, 5 alpha horizontal.
- R6: One cycle after the last write, bank_sel inverts and chroma_mode takes the requested value, both on the same edge on which busy falls.
- R7: busy rises on the edge that samples an accepted start and stays high until the swap. A start pulse that arrives while busy is high has no effect on the ongoing load.
- R8: A start with taps equal to 1, taps equal to 0, taps above 8, or a filter type above 5 produces no write, no busy and no bank change.
- R9: A start with taps equal to 2 and partner_taps equal to 2 produces no write, no busy and no bank change. A start with taps equal to 2 and any other partner count loads normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load request pulse |
| filt_type | input | 3 | Filter type of the table to load |
| taps | input | 4 | Tap count of the filter being loaded |
| partner_taps | input | 4 | Tap count of the other plane in the same direction |
| chroma_mode_in | input | 1 | Chroma coefficient mode to apply at the swap |
| src_addr | output | 9 | Coefficient source read address |
| src_data | input | 16 | Source read data, one cycle after the address |
| wr_en | output | 1 | Coefficient RAM write strobe |
| wr_even_en | output | 1 | Even-half write enable |
| wr_odd_en | output | 1 | Odd-half write enable |
| wr_type | output | 3 | Filter type of the write |
| wr_pair | output | 2 | Tap-pair index |
| wr_phase | output | 6 | Phase index |
| wr_even | output | 16 | Even tap coefficient |
| wr_odd | output | 16 | Odd tap coefficient |
| bank_sel | output | 1 | Bank the scaler reads from |
| chroma_mode | output | 1 | Applied chroma coefficient mode |
| busy | output | 1 | Load in progress |

## Verification
The bench tries three kinds of load. Even tap counts show that every odd slot carries real data. Odd tap counts show that the last pair is padded with zero and that the next phase's first word is not used in its place. A tap count of 2 is tried with a partner count of 2 and with a partner count of 3, which separates the built-in 2-tap case from an ordinary load. Random sequences of filter types and tap counts show that the per-phase base address advances by the latched tap count. A start pulse injected in the middle of a load, with a different type and tap count, shows whether the latched request is protected.

// File: rtl/coefl_pkg.sv
package coefl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_EVEN,
        ST_RD_ODD,
        ST_WRITE,
        ST_SWAP
    } ld_state_e;

    // filter type codes carried on wr_type
    typedef enum logic [2:0] {
        FT_LUMA_V   = 3'd0,
        FT_LUMA_H   = 3'd1,
        FT_CHROMA_V = 3'd2,
        FT_CHROMA_H = 3'd3,
        FT_ALPHA_V  = 3'd4,
        FT_ALPHA_H  = 3'd5
    } filt_type_e;

    localparam logic [2:0] FT_LAST = FT_ALPHA_H;
endpackage

// File: rtl/coefl_walk.sv
// Phase / tap-pair walker with running per-phase base address
module coefl_walk #(
    parameter int PHASES_WR = 33,
    parameter int ADDR_W    = 9,
    parameter int PAIR_W    = 2,
    parameter int PH_W      = 6,
    parameter int TAP_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [TAP_W-1:0]  taps_q,
    output logic [PH_W-1:0]   phase,
    output logic [PAIR_W-1:0] pair,
    output logic [ADDR_W-1:0] base,
    output logic              last_pair,
    output logic              last_phase
);
    logic [TAP_W-1:0] np_m1;

    always_comb begin
        np_m1      = ((taps_q + TAP_W'(1)) >> 1) - TAP_W'(1);
        last_pair  = (TAP_W'(pair) == np_m1);
        last_phase = (phase == PH_W'(PHASES_WR - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
            pair  <= '0;
            base  <= '0;
        end else if (clear) begin
            phase <= '0;
            pair  <= '0;
            base  <= '0;
        end else if (step) begin
            if (last_pair) begin
                pair  <= '0;
                phase <= phase + PH_W'(1);
                base  <= base + ADDR_W'(taps_q);
            end else begin
                pair  <= pair + PAIR_W'(1);
            end
        end
    end
endmodule

// File: rtl/coefl_pack.sv
// Formats and registers one paired coefficient write
module coefl_pack #(
    parameter int COEF_W = 16,
    parameter int PAIR_W = 2,
    parameter int PH_W   = 6,
    parameter int TAP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [2:0]        type_q,
    input  logic [TAP_W-1:0]  taps_q,
    input  logic [PAIR_W-1:0] pair,
    input  logic [PH_W-1:0]   phase,
    input  logic [COEF_W-1:0] even_raw,
    input  logic [COEF_W-1:0] odd_raw,
    output logic              wr_en,
    output logic              wr_even_en,
    output logic              wr_odd_en,
    output logic [2:0]        wr_type,
    output logic [PAIR_W-1:0] wr_pair,
    output logic [PH_W-1:0]   wr_phase,
    output logic [COEF_W-1:0] wr_even,
    output logic [COEF_W-1:0] wr_odd
);
    localparam logic [COEF_W-1:0] LOW_MASK = ~COEF_W'(3);

    logic odd_present;
    assign odd_present = (TAP_W'({pair, 1'b1}) < taps_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en      <= 1'b0;
            wr_even_en <= 1'b0;
            wr_odd_en  <= 1'b0;
            wr_type    <= '0;
            wr_pair    <= '0;
            wr_phase   <= '0;
            wr_even    <= '0;
            wr_odd     <= '0;
        end else begin
            wr_en      <= fire;
            wr_even_en <= fire;
            wr_odd_en  <= fire;
            if (fire) begin
                wr_type  <= type_q;
                wr_pair  <= pair;
                wr_phase <= phase;
                wr_even  <= even_raw & LOW_MASK;
                wr_odd   <= odd_present ? (odd_raw & LOW_MASK) : '0;
            end
        end
    end
endmodule

// File: rtl/coef_bank_loader.sv
module coef_bank_loader
    import coefl_pkg::*;
#(
    parameter int NUM_PHASES = 64,
    parameter int MAX_TAPS   = 8,
    parameter int COEF_W     = 16,
    localparam int PHASES_WR = NUM_PHASES / 2 + 1,
    localparam int TAP_W     = $clog2(MAX_TAPS + 1),
    localparam int PAIR_W    = $clog2((MAX_TAPS + 1) / 2),
    localparam int PH_W      = $clog2(PHASES_WR),
    localparam int ADDR_W    = $clog2(PHASES_WR * MAX_TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        filt_type,
    input  logic [TAP_W-1:0]  taps,
    input  logic [TAP_W-1:0]  partner_taps,
    input  logic              chroma_mode_in,
    output logic [ADDR_W-1:0] src_addr,
    input  logic [COEF_W-1:0] src_data,
    output logic              wr_en,
    output logic              wr_even_en,
    output logic              wr_odd_en,
    output logic [2:0]        wr_type,
    output logic [PAIR_W-1:0] wr_pair,
    output logic [PH_W-1:0]   wr_phase,
    output logic [COEF_W-1:0] wr_even,
    output logic [COEF_W-1:0] wr_odd,
    output logic              bank_sel,
    output logic              chroma_mode,
    output logic              busy
);
    ld_state_e         state_q, state_d;
    logic [TAP_W-1:0]  taps_q;
    logic [2:0]        type_q;
    logic              chroma_req_q;
    logic [COEF_W-1:0] even_q;
    logic [PH_W-1:0]   phase;
    logic [PAIR_W-1:0] pair;
    logic [ADDR_W-1:0] base;
    logic              last_pair, last_phase;
    logic              req_ok, req_skip, accept, fire, capture_even;

    // request qualification
    always_comb begin
        req_ok   = (taps != '0) && (taps <= TAP_W'(MAX_TAPS)) && (filt_type <= FT_LAST);
        req_skip = (taps == TAP_W'(1)) ||
                   ((taps == TAP_W'(2)) && (partner_taps == TAP_W'(2)));
        accept   = start && (state_q == ST_IDLE) && req_ok && !req_skip;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_RD_EVEN;
            ST_RD_EVEN: state_d = ST_RD_ODD;
            ST_RD_ODD:  state_d = ST_WRITE;
            ST_WRITE:   state_d = (last_pair && last_phase) ? ST_SWAP : ST_RD_EVEN;
            ST_SWAP:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // decoded outputs
    always_comb begin
        busy         = (state_q != ST_IDLE);
        capture_even = (state_q == ST_RD_ODD);
        fire         = (state_q == ST_WRITE);
        src_addr     = base + ADDR_W'({pair, 1'b0}) + ADDR_W'(state_q == ST_RD_ODD);
    end

    // request latch, even capture, bank swap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taps_q       <= '0;
            type_q       <= '0;
            chroma_req_q <= 1'b0;
            even_q       <= '0;
            bank_sel     <= 1'b0;
            chroma_mode  <= 1'b0;
        end else begin
            if (accept) begin
                taps_q       <= taps;
                type_q       <= filt_type;
                chroma_req_q <= chroma_mode_in;
            end
            if (capture_even) even_q <= src_data;
            if (state_q == ST_SWAP) begin
                bank_sel    <= ~bank_sel;
                chroma_mode <= chroma_req_q;
            end
        end
    end

    coefl_walk #(
        .PHASES_WR(PHASES_WR), .ADDR_W(ADDR_W), .PAIR_W(PAIR_W),
        .PH_W(PH_W), .TAP_W(TAP_W)
    ) u_walk (
        .clk(clk), .rst_n(rst_n), .clear(accept), .step(fire),
        .taps_q(taps_q), .phase(phase), .pair(pair), .base(base),
        .last_pair(last_pair), .last_phase(last_phase)
    );

    coefl_pack #(
        .COEF_W(COEF_W), .PAIR_W(PAIR_W), .PH_W(PH_W), .TAP_W(TAP_W)
    ) u_pack (
        .clk(clk), .rst_n(rst_n), .fire(fire), .type_q(type_q),
        .taps_q(taps_q), .pair(pair), .phase(phase),
        .even_raw(even_q), .odd_raw(src_data),
        .wr_en(wr_en), .wr_even_en(wr_even_en), .wr_odd_en(wr_odd_en),
        .wr_type(wr_type), .wr_pair(wr_pair), .wr_phase(wr_phase),
        .wr_even(wr_even), .wr_odd(wr_odd)
    );
endmodule

// File: rtl/coef_bank_loader_chk.sv
module coef_bank_loader_chk #(
    parameter int NUM_PHASES = 64,
    parameter int MAX_TAPS   = 8,
    parameter int COEF_W     = 16,
    localparam int PHASES_WR = NUM_PHASES / 2 + 1,
    localparam int PAIR_W    = $clog2((MAX_TAPS + 1) / 2),
    localparam int PH_W      = $clog2(PHASES_WR)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              bank_sel,
    input logic              wr_en,
    input logic [2:0]        wr_type,
    input logic [PAIR_W-1:0] wr_pair,
    input logic [PH_W-1:0]   wr_phase,
    input logic [COEF_W-1:0] wr_even,
    input logic [COEF_W-1:0] wr_odd
);
    AST_PHASE_PAIR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_phase) < PHASES_WR) && (int'(wr_pair) < (MAX_TAPS + 1) / 2)); // R2

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_even[1:0] == 2'b00) && (wr_odd[1:0] == 2'b00)); // R3

    AST_TYPE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_type <= 3'd5)); // R5

    AST_SWAP_ENDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank_sel) |-> ($past(busy) && !busy)); // R6

    AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy); // R7

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R7
endmodule

bind coef_bank_loader coef_bank_loader_chk #(
    .NUM_PHASES(NUM_PHASES), .MAX_TAPS(MAX_TAPS), .COEF_W(COEF_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .bank_sel(bank_sel),
    .wr_en(wr_en), .wr_type(wr_type), .wr_pair(wr_pair), .wr_phase(wr_phase),
    .wr_even(wr_even), .wr_odd(wr_odd)
);

// File: tb/coef_bank_loader_test.sv
`timescale 1ns/1ps
module coef_bank_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  filt_type = '0;
    logic [3:0]  taps = '0;
    logic [3:0]  partner_taps = '0;
    logic        chroma_mode_in = 1'b0;
    logic [8:0]  src_addr;
    logic [15:0] src_data = '0;
    logic        wr_en, wr_even_en, wr_odd_en, bank_sel, chroma_mode, busy;
    logic [2:0]  wr_type;
    logic [1:0]  wr_pair;
    logic [5:0]  wr_phase;
    logic [15:0] wr_even, wr_odd;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // expected-load context used by the write monitor
    bit exp_active = 0;
    int exp_type = 0, exp_taps = 1, wr_idx = 0;

    always #4 clk = ~clk;

    coef_bank_loader uut (
        .clk(clk), .rst_n(rst_n), .start(start), .filt_type(filt_type),
        .taps(taps), .partner_taps(partner_taps), .chroma_mode_in(chroma_mode_in),
        .src_addr(src_addr), .src_data(src_data),
        .wr_en(wr_en), .wr_even_en(wr_even_en), .wr_odd_en(wr_odd_en),
        .wr_type(wr_type), .wr_pair(wr_pair), .wr_phase(wr_phase),
        .wr_even(wr_even), .wr_odd(wr_odd),
        .bank_sel(bank_sel), .chroma_mode(chroma_mode), .busy(busy)
    );

    function automatic logic [15:0] coef_fn(int a);
        return 16'((a * 37 + 16'h1235) ^ (a << 7));
    endfunction

    // stub source memory, one cycle of read latency
    always @(posedge clk) src_data <= coef_fn(int'(src_addr));

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // write monitor
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (!exp_active) begin
                chk(0, "R8 unexpected write", 1, 0);
            end else begin
                int np, ph, pr, ea, oa;
                np = (exp_taps + 1) / 2;
                ph = wr_idx / np;
                pr = wr_idx % np;
                ea = coef_fn(ph * exp_taps + 2 * pr) & 16'hFFFC;
                oa = (2 * pr + 1 < exp_taps) ? (coef_fn(ph * exp_taps + 2 * pr + 1) & 16'hFFFC) : 0;
                chk(int'(wr_phase) == ph, "R2 phase", int'(wr_phase), ph);
                chk(int'(wr_pair) == pr, "R2 pair", int'(wr_pair), pr);
                chk(int'(wr_even) == ea, "R3 even", int'(wr_even), ea);
                if (2 * pr + 1 < exp_taps)
                    chk(int'(wr_odd) == oa, "R3 odd", int'(wr_odd), oa);
                else
                    chk(wr_odd == 16'h0, "R4 odd pad", int'(wr_odd), 0);
                chk(wr_even_en && wr_odd_en, "R5 enables", {wr_even_en, wr_odd_en}, 3);
                chk(int'(wr_type) == exp_type, "R5 type", int'(wr_type), exp_type);
                wr_idx++;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic pulse(int s, int t, int p, bit c);
        @(negedge clk);
        start = 1'b1; filt_type = 3'(s); taps = 4'(t); partner_taps = 4'(p); chroma_mode_in = c;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_load(int s, int t, int p, bit c, bit inject);
        bit b0;
        int np;
        b0 = bank_sel;
        np = (t + 1) / 2;
        exp_active = 1; exp_type = s; exp_taps = t; wr_idx = 0;
        pulse(s, t, p, c);
        chk(busy == 1'b1, "R7 busy rise", busy, 1);
        if (inject) begin
            repeat (25) @(negedge clk);
            pulse((s + 3) % 6, (t == 3) ? 6 : 3, 5, ~c);
            chk(busy == 1'b1, "R7 start ignored while busy", busy, 1);
        end
        while (busy) @(negedge clk);
        chk(wr_idx == 33 * np, "R2 write count", wr_idx, 33 * np);
        chk(bank_sel == ~b0, "R6 bank toggled", bank_sel, ~b0);
        chk(chroma_mode == c, "R6 chroma mode", chroma_mode, c);
        exp_active = 0;
        @(negedge clk);
    endtask

    task automatic do_skip(int s, int t, int p, string req);
        bit b0;
        b0 = bank_sel;
        exp_active = 0;
        pulse(s, t, p, ~chroma_mode);
        chk(busy == 1'b0, req, busy, 0);
        repeat (10) @(negedge clk);
        chk(bank_sel == b0 && !busy, req, bank_sel, b0);
    endtask

    initial begin
        void'($urandom(32'd4417));
        repeat (3) @(negedge clk);
        chk(bank_sel == 0 && chroma_mode == 0 && busy == 0 && wr_en == 0,
            "R1 reset state", {bank_sel, chroma_mode, busy, wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        do_load(1, 8, 8, 1'b1, 0);          // full even pairs
        do_load(2, 5, 4, 1'b0, 0);          // odd pad on last pair (R4)
        do_load(0, 2, 3, 1'b1, 0);          // R9 2-tap with partner 3 loads
        do_skip(0, 2, 2, "R9 2-tap hardwired skip");
        do_skip(3, 1, 4, "R8 single tap skip");
        do_skip(4, 0, 4, "R8 zero taps ignored");
        do_skip(4, 9, 4, "R8 taps above max ignored");
        do_skip(6, 4, 4, "R8 type above 5 ignored");
        do_load(5, 3, 3, 1'b1, 1);          // R7 mid-load start ignored
        do_load(4, 7, 2, 1'b0, 1);

        // random mix
        for (int i = 0; i < 14; i++) begin
            int s, t, p;
            bit c;
            s = int'($urandom_range(0, 5));
            t = int'($urandom_range(1, 8));
            p = int'($urandom_range(1, 8));
            c = 1'($urandom_range(0, 1));
            if (t == 1 || (t == 2 && p == 2)) do_skip(s, t, p, "R8 R9 random skip");
            else do_load(s, t, p, c, 0);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule